// File: doc/BRIEF.md
# Prescaled Timer/Event Counter

This block is a small wrap-around counter that runs on the instruction clock. A free-running binary prescaler divides that clock by 2^PRE_W, which is 64 by default. In timer mode the counter takes one step each time the prescaler rolls over. In event mode the counter takes one step on each rising edge of an external event pin. The event pin is brought into the clock domain by a synchronizer before the edge is detected.

Software sets the period through a preset latch. A write to the latch also loads the counter. When the counter passes its all-ones value it reloads from the latch, so the periods repeat without drift. On each wrap the counter sets a sticky timer flag and raises a single-cycle interrupt request. A halt input freezes the prescaler and the counter. The CPU and its bus decoding stay outside this block.

Top module: `tmr_evt_counter`

## Requirements
- R1: After a synchronous reset, count_o, flag_o and irq_o are 0, the preset latch holds 0 and the prescaler starts from 0.
- R2: In timer mode (mode_sel = 0), count_o increases by one once every 2^PRE_W cycles (64 by default), on the cycle in which the prescaler passes its all-ones value.
- R3: At a wrap, the counter reloads from the preset latch. With preset n, successive wraps are (2^CNT_W − n) × 2^PRE_W cycles apart: 1024 cycles for n = 0 and 64 cycles for n = 15 at the default sizes.
- R4: While halt is 1, the prescaler is frozen, count_o does not change except through a preset write, and no wrap occurs. When halt returns to 0, counting resumes from the frozen prescaler phase.
- R5: In event mode (mode_sel = 1), count_o increases by one for each low-to-high transition of evt_in that holds each level for at least 2 cycles. The new value appears on count_o 3 clock edges after the first edge that samples evt_in high.
- R6: A wrap sets flag_o on the same edge that the reload happens. flag_clr clears flag_o on the next edge. If a wrap and flag_clr occur in the same cycle, flag_o ends up 1.
- R7: irq_o is high for exactly one cycle per wrap, and it rises together with the reload.
- R8: When preset_we is 1, both the latch and count_o take preset_wdata on the next edge. The write takes priority over an advance in the same cycle, and it leaves the prescaler phase unchanged.
- R9: In event mode, prescaler rollovers do not move the counter. In timer mode, evt_in edges do not move the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Freezes the prescaler and the counter |
| mode_sel | input | 1 | Selects the count source: 0 = timer (prescaler), 1 = event pin |
| preset_we | input | 1 | Writes the preset latch and loads the counter |
| preset_wdata | input | CNT_W | Preset value |
| flag_clr | input | 1 | Clears the timer flag |
| evt_in | input | 1 | External event pin (asynchronous) |
| count_o | output | CNT_W | Current counter value |
| flag_o | output | 1 | Sticky timer flag |
| irq_o | output | 1 | Single-cycle interrupt request on wrap |

## Verification
The bench builds the block with its default sizes: PRE_W = 6, CNT_W = 4 and two synchronizer stages. At these sizes the longest period (preset 0, 1024 cycles) and the shortest (preset 15, 64 cycles) can both be measured directly, each within a few thousand cycles. The small counter also makes wraps frequent enough to exercise the reload several times. The same sizes bring into reach a flag clear that lands on the very cycle of a wrap, a halt held across a prescaler rollover, and a count in event mode that crosses the wrap point.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    SRC_PRESCALE = 1'b0,
    SRC_EVENT    = 1'b1
  } tmr_src_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic halt,
  output logic tick
);
  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst)        div_q <= '0;
    else if (!halt) div_q <= div_q + 1'b1;
  end

  // one-cycle strobe in the cycle the divider rolls over
  assign tick = !halt && (&div_q);
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] && !last_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             irq
);
  logic [CNT_W-1:0] reload_q;
  logic             wrap;

  assign wrap = advance && !load_we && (&count);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      count    <= '0;
    end else if (load_we) begin
      reload_q <= load_data;
      count    <= load_data;
    end else if (advance) begin
      count <= wrap ? reload_q : count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= wrap;
      if (wrap)          flag <= 1'b1;   // set dominates clear
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_evt_counter.sv
module tmr_evt_counter #(
  parameter int PRE_W       = 6,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic             mode_sel,
  input  logic             preset_we,
  input  logic [CNT_W-1:0] preset_wdata,
  input  logic             flag_clr,
  input  logic             evt_in,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             irq_o
);
  import tmr_pkg::*;

  logic     pre_tick;
  logic     evt_rise;
  logic     step;
  tmr_src_e src;

  assign src = tmr_src_e'(mode_sel);

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .halt(halt), .tick(pre_tick)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(evt_in), .rise(evt_rise)
  );

  always_comb begin
    unique case (src)
      SRC_EVENT: step = evt_rise && !halt;
      default:   step = pre_tick;
    endcase
  end

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .advance(step),
    .load_we(preset_we), .load_data(preset_wdata), .flag_clr(flag_clr),
    .count(count_o), .flag(flag_o), .irq(irq_o)
  );
endmodule

// File: rtl/tmr_evt_counter_chk.sv
module tmr_evt_counter_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             halt,
  input logic             preset_we,
  input logic [CNT_W-1:0] preset_wdata,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count_o,
  input logic             flag_o,
  input logic             irq_o
);
  // R7: request lasts a single cycle
  a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  // R6: a request always comes with the flag set
  a_r6_irq_sets_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);
  // R6: the flag is sticky without a clear
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !flag_clr) |=> flag_o);
  // R4: halt freezes the count and blocks wraps
  a_r4_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    (halt && !preset_we) |=> ($stable(count_o) && !irq_o));
  // R8: a write loads the counter on the next edge
  a_r8_write_loads: assert property (@(posedge clk) disable iff (rst)
    preset_we |=> (count_o == $past(preset_wdata) && !irq_o));
endmodule

bind tmr_evt_counter tmr_evt_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .halt(halt), .preset_we(preset_we),
  .preset_wdata(preset_wdata), .flag_clr(flag_clr),
  .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/test_tmr_evt_counter.sv
`timescale 1ns/1ps
module test_tmr_evt_counter;
  localparam int PRE_W = 6;
  localparam int CNT_W = 4;
  localparam int PRE_N = 1 << PRE_W;
  localparam int CNT_N = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt = 1'b0, mode_sel = 1'b0, preset_we = 1'b0, flag_clr = 1'b0, evt_in = 1'b0;
  logic [CNT_W-1:0] preset_wdata = '0;
  logic [CNT_W-1:0] count_o;
  logic flag_o, irq_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int cyc = 0;

  // reference model state
  int m_pre, m_cnt, m_lat, m_s1, m_s2, m_s3;
  bit m_flag, m_irq;

  always #5 clk = ~clk;

  tmr_evt_counter #(.PRE_W(PRE_W), .CNT_W(CNT_W), .SYNC_STAGES(2)) i_tmr_evt_counter (
    .clk(clk), .rst(rst), .halt(halt), .mode_sel(mode_sel),
    .preset_we(preset_we), .preset_wdata(preset_wdata), .flag_clr(flag_clr),
    .evt_in(evt_in), .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // behavioural model, updated at each rising edge from the stable inputs
  always @(posedge clk) begin
    bit tick, rise, adv, wrap;
    cyc++;
    if (rst) begin
      m_pre = 0; m_cnt = 0; m_lat = 0; m_flag = 0; m_irq = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      tick = !halt && (m_pre == PRE_N-1);
      rise = (m_s2 == 1) && (m_s3 == 0);
      adv  = mode_sel ? (rise && !halt) : tick;
      wrap = 0;
      if (preset_we) begin
        m_lat = int'(preset_wdata); m_cnt = m_lat;
      end else if (adv) begin
        if (m_cnt == CNT_N-1) begin m_cnt = m_lat; wrap = 1; end
        else m_cnt++;
      end
      m_irq = wrap;
      if (wrap) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(evt_in);
      if (!halt) m_pre = (m_pre + 1) % PRE_N;
    end
    #2;
    if (!rst) begin
      check("R2 count vs model", int'(count_o), m_cnt);
      check("R6 flag vs model", int'(flag_o), int'(m_flag));
      check("R7 irq vs model", int'(irq_o), int'(m_irq));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // wait for the next irq pulse (sampled at negedge); returns cycle stamp
  task automatic wait_irq(output int stamp);
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!irq_o && guard < 5000);
    stamp = cyc;
  endtask

  task automatic write_preset(input int v);
    preset_we = 1'b1; preset_wdata = CNT_W'(v);
    @(negedge clk);
    preset_we = 1'b0;
  endtask

  task automatic pulse_evt(input int hi, input int lo);
    evt_in = 1'b1; step(hi);
    evt_in = 1'b0; step(lo);
  endtask

  initial begin
    int t0, t1, c0;
    step(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 count after reset", int'(count_o), 0);
    check("R1 flag after reset", int'(flag_o), 0);
    check("R1 irq after reset", int'(irq_o), 0);

    // R2: one step per prescaler period
    wait_irq(t0);              // preset 0: first wrap
    c0 = int'(count_o);
    step(PRE_N);
    check("R2 step after one prescaler period", int'(count_o), c0 + 1);

    // R3: periods for presets 15, 0 and 10
    write_preset(15);
    check("R8 write loads counter", int'(count_o), 15);
    wait_irq(t0); wait_irq(t1);
    check("R3 period preset 15", t1 - t0, 16 * PRE_N - 15 * PRE_N);
    check("R3 reload value preset 15", int'(count_o), 15);
    write_preset(0);
    wait_irq(t0); wait_irq(t1);
    check("R3 period preset 0", t1 - t0, CNT_N * PRE_N);
    write_preset(10);
    wait_irq(t0); wait_irq(t1);
    check("R3 period preset 10", t1 - t0, (CNT_N - 10) * PRE_N);

    // R7: irq drops after one cycle
    @(negedge clk);
    check("R7 irq single cycle", int'(irq_o), 0);

    // R6: clear held across a wrap; set wins
    flag_clr = 1'b1;
    step(2);
    check("R6 clear drops flag", int'(flag_o), 0);
    wait_irq(t0);
    check("R6 set wins over clear", int'(flag_o), 1);
    @(negedge clk);
    check("R6 clear after wrap", int'(flag_o), 0);
    flag_clr = 1'b0;

    // R4: halt across several prescaler periods
    halt = 1'b1;
    @(negedge clk);
    c0 = int'(count_o);
    step(3 * PRE_N);
    check("R4 count frozen in halt", int'(count_o), c0);
    halt = 1'b0;
    step(2 * PRE_N);

    // R9: event edges ignored in timer mode (model tracks the count)
    for (int i = 0; i < 6; i++) pulse_evt(3, 3);

    // R5: event mode, crossing the wrap
    mode_sel = 1'b1;
    write_preset(12);
    for (int i = 0; i < 3; i++) pulse_evt(2, 2);
    step(2);
    check("R5 three edges counted", int'(count_o), 15);
    evt_in = 1'b1; step(3);
    check("R5 wrap in event mode", int'(irq_o), 1);
    check("R5 reload in event mode", int'(count_o), 12);
    evt_in = 1'b0; step(3);

    // R9: prescaler ignored in event mode
    c0 = int'(count_o);
    step(3 * PRE_N);
    check("R9 no prescaler steps in event mode", int'(count_o), c0);

    // R4: edges during halt are not counted
    halt = 1'b1;
    pulse_evt(3, 3);
    halt = 1'b0; step(2);
    check("R4 edges dropped in halt", int'(count_o), c0);

    mode_sel = 1'b0;
    step(4 * PRE_N);
    finish_run();
  end

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule